// File: doc/BRIEF.md
# Buffered SPI Master with Soft Disable

This block is a byte-wide SPI master for a CPU-facing peripheral slot. Software writes a control byte and transmit bytes through a single write port. It reads received data, the control settings and four status flags straight off output ports. A transmit holding register sits in front of the shift register. One byte can wait while another is shifted, and the waiting byte starts as soon as the current one ends. Finished bytes land in a receive register, and a one-cycle acknowledge input clears it for the next byte.

The block has two levels of reset. The active-low system reset clears everything. Writing the enable bit low is a lighter reset. It stops any transfer mid-byte, empties the shift register and bit counter, forces the transmit-empty flag and drops the port-enable output. Control bits and the receive-full, overrun and mode-fault flags keep their values, so pending events can still be serviced after shutdown. When mode-fault detection is armed and the slave-select input goes low, the block clears its own enable bit, which applies the same light reset.

Top module: `spi_pr_top`

## Requirements
- R1: After system reset, txEmpty=1; rxFull, overrun, modeFault, portEn, sclk and all three interrupt outputs are 0; ctrlOut=0x00.
- R2: A transfer moves 8 bits MSB first in mode 0. SCLK idles low, MOSI holds each bit from before its rising edge, and MISO is sampled on the rising edge. The byte sampled from MISO appears on rxData.
- R3: rxFull goes to 1 when a finished byte is copied into rxData. It stays 1 until an rxAck pulse, which clears rxFull and overrun. rxData changes only when rxFull rises.
- R4: An accepted data write (wrEn=1, wrSel=1) clears txEmpty in the next cycle. txEmpty returns to 1 in the cycle the byte moves into the shift register.
- R5: A data write while txEmpty=0 or while enable is 0 is ignored: the queued byte is neither replaced nor sent twice.
- R6: A byte queued during a transfer starts right after the previous byte's last falling SCLK edge. The spacing between rising edges across the byte boundary equals the normal SCLK period.
- R7: Control bits [6:5] select the SCLK period: 0→2, 1→8, 2→32, 3→128 system clocks.
- R8: If a byte finishes while rxFull=1, overrun goes to 1, the new byte is dropped and rxData keeps the older byte.
- R9: irqRx = rxFull AND ctrl bit 1; irqTx = txEmpty AND ctrl bit 2; irqErr = ctrl bit 3 AND (overrun OR modeFault).
- R10: While enable (ctrl bit 0, also driven on portEn) is 0, any transfer is abandoned, SCLK returns low and txEmpty is 1. Control bits [6:1], rxFull, overrun and rxData are kept.
- R11: With ctrl bit 4 set and the block enabled, ssN=0 sets modeFault and clears the enable bit. With bit 4 clear, ssN has no effect. A control write with bit 7 set clears modeFault.
- R12: After a disable/enable cycle, the next transfer begins at bit 7 and sends and receives a whole, correct byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low system reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 = control byte, 1 = transmit byte |
| wrData | input | 8 | Write data |
| rxAck | input | 1 | Pulse: receive byte consumed, clears rxFull and overrun |
| rxData | output | 8 | Receive data register |
| ctrlOut | output | 8 | Control readback: [0] enable, [1] rx irq en, [2] tx irq en, [3] error irq en, [4] mode-fault en, [6:5] rate, [7] reads 0 |
| txEmpty | output | 1 | Transmit holding register free |
| rxFull | output | 1 | Receive register holds an unread byte |
| overrun | output | 1 | A byte was lost to a full receive register |
| modeFault | output | 1 | Slave select was pulled low while armed |
| irqRx | output | 1 | Receive interrupt request |
| irqTx | output | 1 | Transmit interrupt request |
| irqErr | output | 1 | Error interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | input | 1 | Slave-select sense input for mode fault |
| portEn | output | 1 | Serial pins owned by the block |

## Verification
The hardest state to reach is a disable that lands partway through a byte while an unread byte already sits in the receive register. The bench first finishes a byte and leaves it unacknowledged. It then starts a second byte at the slowest rate and counts rising SCLK edges from the bench slave, so the control write that drops the enable lands after three bits. It then checks which state was kept and which was discarded. Finally it re-enables, resets the slave's bit position and requires a clean full byte in both directions.

// File: rtl/spi_pr_pkg.sv
package spi_pr_pkg;

  // Control byte field positions (software-visible layout)
  localparam int CB_EN     = 0;
  localparam int CB_RXIE   = 1;
  localparam int CB_TXIE   = 2;
  localparam int CB_ERRIE  = 3;
  localparam int CB_MODFEN = 4;
  localparam int CB_RATE_L = 5;
  localparam int CB_MFCLR  = 7;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadTx;     // capture write data into holding register
    logic loadShift;  // holding register -> shift register
    logic sample;     // latch MISO (rising SCLK)
    logic shift;      // shift left, insert sampled bit (falling SCLK)
    logic capture;    // completed byte -> receive register
    logic clear;      // partial reset of the shifter
  } dpStrobe_t;

endpackage

// File: rtl/spi_pr_ctrl.sv
module spi_pr_ctrl
  import spi_pr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RATE_W    = 2,
  parameter int RATE_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxAck,
  input  logic              ssN,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] ctrlOut,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              overrun,
  output logic              modeFault,
  output logic              sclk,
  output logic              active,
  output logic              enable,
  output logic              rxIe,
  output logic              txIe,
  output logic              errIe
);

  localparam int BIT_W  = $clog2(DATA_W);
  localparam int HCNT_W = RATE_STEP * ((1 << RATE_W) - 1) + 1;

  logic              modfEn;
  logic [RATE_W-1:0] rate;
  logic [HCNT_W-1:0] halfCnt;
  logic [HCNT_W-1:0] halfLen;
  logic [BIT_W-1:0]  bitCnt;

  logic ctrlWr, dataWr, modfHit;
  logic halfDone, riseEv, fallEv, lastBit, startEv;

  assign halfLen  = HCNT_W'(1) << (RATE_STEP * int'(rate));
  assign ctrlWr   = wrEn && !wrSel;
  assign dataWr   = wrEn && wrSel && enable && txEmpty;
  assign modfHit  = enable && modfEn && !ssN;
  assign halfDone = active && (halfCnt >= halfLen - HCNT_W'(1));
  assign riseEv   = halfDone && !sclk;
  assign fallEv   = halfDone && sclk;
  assign lastBit  = fallEv && (bitCnt == BIT_W'(DATA_W - 1));
  assign startEv  = enable && !txEmpty && (!active || lastBit);

  always_comb begin
    strobe.loadTx    = dataWr;
    strobe.loadShift = startEv;
    strobe.sample    = riseEv;
    strobe.shift     = fallEv;
    strobe.capture   = lastBit && !rxFull;
    strobe.clear     = !enable;
  end

  always_comb begin
    ctrlOut = '0;
    ctrlOut[CB_EN]     = enable;
    ctrlOut[CB_RXIE]   = rxIe;
    ctrlOut[CB_TXIE]   = txIe;
    ctrlOut[CB_ERRIE]  = errIe;
    ctrlOut[CB_MODFEN] = modfEn;
    ctrlOut[CB_RATE_L +: RATE_W] = rate;
  end

  // Control bits and mode fault: system reset only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable    <= 1'b0;
      rxIe      <= 1'b0;
      txIe      <= 1'b0;
      errIe     <= 1'b0;
      modfEn    <= 1'b0;
      rate      <= '0;
      modeFault <= 1'b0;
    end else begin
      if (ctrlWr) begin
        enable <= wrData[CB_EN];
        rxIe   <= wrData[CB_RXIE];
        txIe   <= wrData[CB_TXIE];
        errIe  <= wrData[CB_ERRIE];
        modfEn <= wrData[CB_MODFEN];
        rate   <= wrData[CB_RATE_L +: RATE_W];
        if (wrData[CB_MFCLR]) modeFault <= 1'b0;
      end
      if (modfHit) begin
        modeFault <= 1'b1;
        enable    <= 1'b0;
      end
    end
  end

  // Receive flags: survive disable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (rxAck) begin
        rxFull  <= 1'b0;
        overrun <= 1'b0;
      end
      if (lastBit) begin
        if (rxFull) overrun <= 1'b1;
        else        rxFull  <= 1'b1;
      end
    end
  end

  // Transmit flag and sequencer: partial reset while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
      active  <= 1'b0;
      halfCnt <= '0;
      bitCnt  <= '0;
      sclk    <= 1'b0;
    end else if (!enable) begin
      txEmpty <= 1'b1;
      active  <= 1'b0;
      halfCnt <= '0;
      bitCnt  <= '0;
      sclk    <= 1'b0;
    end else begin
      if (startEv)     txEmpty <= 1'b1;
      else if (dataWr) txEmpty <= 1'b0;

      if (startEv) begin
        active  <= 1'b1;
        halfCnt <= '0;
        bitCnt  <= '0;
        sclk    <= 1'b0;
      end else if (active) begin
        if (halfDone) begin
          halfCnt <= '0;
          sclk    <= ~sclk;
          if (fallEv) begin
            if (lastBit) active <= 1'b0;
            else         bitCnt <= bitCnt + BIT_W'(1);
          end
        end else begin
          halfCnt <= halfCnt + HCNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/spi_pr_dp.sv
module spi_pr_dp
  import spi_pr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              miso,
  output logic [DATA_W-1:0] rxData,
  output logic              txBit
);

  logic [DATA_W-1:0] txHold;
  logic [DATA_W-1:0] shiftReg;
  logic              sampled;

  assign txBit = shiftReg[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold   <= '0;
      shiftReg <= '0;
      sampled  <= 1'b0;
      rxData   <= '0;
    end else begin
      if (strobe.loadTx) txHold <= wrData;

      if (strobe.clear) begin
        shiftReg <= '0;
        sampled  <= 1'b0;
      end else begin
        if (strobe.loadShift)  shiftReg <= txHold;
        else if (strobe.shift) shiftReg <= {shiftReg[DATA_W-2:0], sampled};
        if (strobe.sample)     sampled  <= miso;
      end

      if (strobe.capture) rxData <= {shiftReg[DATA_W-2:0], sampled};
    end
  end

endmodule

// File: rtl/spi_pr_top.sv
module spi_pr_top
  import spi_pr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RATE_W    = 2,
  parameter int RATE_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxAck,
  output logic [DATA_W-1:0] rxData,
  output logic [DATA_W-1:0] ctrlOut,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              overrun,
  output logic              modeFault,
  output logic              irqRx,
  output logic              irqTx,
  output logic              irqErr,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  input  logic              ssN,
  output logic              portEn
);

  dpStrobe_t strobe;
  logic active, enable, rxIe, txIe, errIe, txBit;

  spi_pr_ctrl #(.DATA_W(DATA_W), .RATE_W(RATE_W), .RATE_STEP(RATE_STEP)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rxAck(rxAck), .ssN(ssN), .strobe(strobe), .ctrlOut(ctrlOut),
    .txEmpty(txEmpty), .rxFull(rxFull), .overrun(overrun),
    .modeFault(modeFault), .sclk(sclk), .active(active), .enable(enable),
    .rxIe(rxIe), .txIe(txIe), .errIe(errIe)
  );

  spi_pr_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .miso(miso), .rxData(rxData), .txBit(txBit)
  );

  assign mosi   = active && txBit;
  assign portEn = enable;
  assign irqRx  = rxFull && rxIe;
  assign irqTx  = txEmpty && txIe;
  assign irqErr = errIe && (overrun || modeFault);

endmodule

// File: rtl/spi_pr_chk.sv
module spi_pr_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxAck,
  input logic [DATA_W-1:0] rxData,
  input logic              txEmpty,
  input logic              rxFull,
  input logic              overrun,
  input logic              modeFault,
  input logic              sclk,
  input logic              portEn
);

  AST_DISABLE_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> (!sclk && txEmpty)); // R10

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $stable(rxData)); // R8

  AST_RXFULL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !rxAck) |=> rxFull); // R3

  AST_RXDATA_ON_FILL: assert property (@(posedge clk) disable iff (!rstN)
    !$rose(rxFull) |-> $stable(rxData)); // R3

  AST_MODF_DROPS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeFault) |-> !portEn); // R11

  AST_LOAD_AT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(txEmpty) && portEn) |-> !sclk); // R4

endmodule

bind spi_pr_top spi_pr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxAck(rxAck), .rxData(rxData),
  .txEmpty(txEmpty), .rxFull(rxFull), .overrun(overrun),
  .modeFault(modeFault), .sclk(sclk), .portEn(portEn)
);

// File: tb/sim_spi_pr_top.sv
`timescale 1ns/1ps
module sim_spi_pr_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrSel = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rxAck = 1'b0;
  logic [7:0] rxData, ctrlOut;
  logic       txEmpty, rxFull, overrun, modeFault;
  logic       irqRx, irqTx, irqErr, sclk, mosi, miso, ssN, portEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  spi_pr_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rxAck(rxAck), .rxData(rxData), .ctrlOut(ctrlOut), .txEmpty(txEmpty),
    .rxFull(rxFull), .overrun(overrun), .modeFault(modeFault),
    .irqRx(irqRx), .irqTx(irqTx), .irqErr(irqErr), .sclk(sclk),
    .mosi(mosi), .miso(miso), .ssN(ssN), .portEn(portEn)
  );

  // Bench slave: mode 0, sends slvBytes in order, logs what it receives
  logic [7:0] slvBytes [0:3];
  logic       slvRst = 1'b0;
  int         outCnt = 0, outIdx = 0;
  int         inCnt = 0, nIn = 0, nRise = 0;
  logic [7:0] inShift = 8'h00;
  logic [7:0] slvLog [0:3];
  int         riseT [0:31];

  assign miso = slvBytes[outIdx & 3][7 - outCnt];
  initial ssN = 1'b1;

  always @(negedge sclk or posedge slvRst) begin
    if (slvRst) begin
      outCnt = 0; outIdx = 0;
    end else if (outCnt == 7) begin
      outCnt = 0; outIdx = outIdx + 1;
    end else begin
      outCnt = outCnt + 1;
    end
  end

  always @(posedge sclk or posedge slvRst) begin
    if (slvRst) begin
      inCnt = 0; nIn = 0; nRise = 0; inShift = 8'h00;
    end else begin
      if (nRise < 32) riseT[nRise] = cyc;
      nRise = nRise + 1;
      inShift = {inShift[6:0], mosi};
      inCnt = inCnt + 1;
      if (inCnt == 8) begin
        if (nIn < 4) slvLog[nIn] = inShift;
        nIn = nIn + 1;
        inCnt = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [7:0] v);
    @(negedge clk); wrEn = 1'b1; wrSel = 1'b0; wrData = v;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic wrTx(input logic [7:0] v);
    @(negedge clk); wrEn = 1'b1; wrSel = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); rxAck = 1'b1;
    @(negedge clk); rxAck = 1'b0;
  endtask

  task automatic slaveReset(input logic [7:0] b0, input logic [7:0] b1);
    slvBytes[0] = b0; slvBytes[1] = b1; slvBytes[2] = 8'h00; slvBytes[3] = 8'h00;
    @(negedge clk); slvRst = 1'b1;
    @(negedge clk); slvRst = 1'b0;
  endtask

  // wait until the slave has seen n bytes, then let the last falling edge pass
  task automatic waitBytes(input int n, input string req);
    int k;
    k = 0;
    while (nIn < n && k < 20000) begin @(negedge clk); k++; end
    if (k >= 20000) chk({req, " timeout"}, nIn, n);
    repeat (150) @(negedge clk);
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1 txEmpty", txEmpty, 1);
    chk("R1 rxFull", rxFull, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 modeFault", modeFault, 0);
    chk("R1 portEn", portEn, 0);
    chk("R1 sclk", sclk, 0);
    chk("R1 irqs", {irqRx, irqTx, irqErr}, 0);
    chk("R1 ctrlOut", ctrlOut, 8'h00);
  endtask

  task automatic tBasic();
    slaveReset(8'h3C, 8'h00);
    wrCtrl(8'h01);
    chk("R9 irqTx masked", irqTx, 0);
    wrTx(8'hA5);
    waitBytes(1, "R2");
    chk("R2 mosi byte", slvLog[0], 8'hA5);
    chk("R2 miso byte", rxData, 8'h3C);
    chk("R3 rxFull set", rxFull, 1);
    chk("R9 irqRx masked", irqRx, 0);
    wrCtrl(8'h07);
    chk("R9 irqRx enabled", irqRx, 1);
    chk("R9 irqTx enabled", irqTx, 1);
    ack();
    chk("R3 rxFull cleared", rxFull, 0);
    chk("R9 irqRx drops", irqRx, 0);
    wrCtrl(8'h01);
  endtask

  task automatic tQueue();
    slaveReset(8'h11, 8'h22);
    wrTx(8'hC3);
    chk("R4 txEmpty low after write", txEmpty, 0);
    @(negedge clk);
    chk("R4 txEmpty high after load", txEmpty, 1);
    wrTx(8'h5A);
    chk("R4 second byte queued", txEmpty, 0);
    wrTx(8'hFF);
    chk("R5 txEmpty still low", txEmpty, 0);
    waitBytes(2, "R5");
    repeat (200) @(negedge clk);
    chk("R5 byte count", nIn, 2);
    chk("R5 first byte", slvLog[0], 8'hC3);
    chk("R5 queued byte kept", slvLog[1], 8'h5A);
    ack();
  endtask

  task automatic tRates();
    for (int r = 0; r < 4; r++) begin
      slaveReset(8'h81, 8'h00);
      wrCtrl(8'h01 | 8'(r << 5));
      wrTx(8'h42);
      waitBytes(1, "R7");
      chk($sformatf("R7 period rate%0d", r), riseT[1] - riseT[0], 2 << (2 * r));
      chk($sformatf("R7 byte rate%0d", r), rxData, 8'h81);
      ack();
    end
    wrCtrl(8'h01);
  endtask

  task automatic tBackToBack();
    int k;
    slaveReset(8'h96, 8'h69);
    wrCtrl(8'h21);
    wrTx(8'hE1);
    k = 0;
    while (!txEmpty && k < 100) begin @(negedge clk); k++; end
    wrTx(8'h1E);
    waitBytes(2, "R6");
    chk("R6 rise count", nRise, 16);
    chk("R6 boundary spacing", riseT[8] - riseT[7], 8);
    chk("R6 inner spacing", riseT[7] - riseT[6], 8);
    chk("R6 second byte out", slvLog[1], 8'h1E);
    ack();
    wrCtrl(8'h01);
  endtask

  task automatic tOverrun();
    slaveReset(8'h5C, 8'hC5);
    wrCtrl(8'h09);
    wrTx(8'h01);
    waitBytes(1, "R8");
    chk("R8 first byte", rxData, 8'h5C);
    chk("R9 irqErr idle", irqErr, 0);
    wrTx(8'h02);
    waitBytes(2, "R8");
    chk("R8 overrun set", overrun, 1);
    chk("R8 data kept", rxData, 8'h5C);
    chk("R9 irqErr on overrun", irqErr, 1);
    ack();
    chk("R3 overrun cleared", overrun, 0);
    chk("R3 rxFull cleared", rxFull, 0);
    wrCtrl(8'h01);
  endtask

  task automatic tAbort();
    int k;
    slaveReset(8'h77, 8'hB4);
    wrTx(8'h3D);
    waitBytes(1, "R10");
    wrCtrl(8'h6F);
    wrTx(8'hF0);
    k = 0;
    while (nRise < 11 && k < 5000) begin @(negedge clk); k++; end
    wrCtrl(8'h6E);
    @(negedge clk);
    chk("R10 portEn low", portEn, 0);
    chk("R10 sclk low", sclk, 0);
    chk("R10 txEmpty forced", txEmpty, 1);
    chk("R10 ctrl kept", ctrlOut, 8'h6E);
    chk("R10 rxFull kept", rxFull, 1);
    chk("R10 rxData kept", rxData, 8'h77);
    repeat (400) @(negedge clk);
    chk("R10 no edges while off", nRise, 11);
    chk("R10 overrun clear", overrun, 0);
    wrTx(8'h99);
    chk("R5 write while disabled", txEmpty, 1);
    ack();
    slaveReset(8'hD2, 8'h00);
    wrCtrl(8'h6F);
    repeat (600) @(negedge clk);
    chk("R5 nothing sent after enable", nIn, 0);
    wrTx(8'h4B);
    waitBytes(1, "R12");
    chk("R12 clean byte out", slvLog[0], 8'h4B);
    chk("R12 clean byte in", rxData, 8'hD2);
    ack();
    wrCtrl(8'h01);
  endtask

  task automatic tModeFault();
    wrCtrl(8'h01);
    @(negedge clk); ssN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 ignored when not armed", modeFault, 0);
    chk("R11 enable kept", portEn, 1);
    ssN = 1'b1;
    wrCtrl(8'h19);
    @(negedge clk); ssN = 1'b0;
    @(negedge clk);
    chk("R11 modeFault set", modeFault, 1);
    chk("R11 enable cleared", ctrlOut[0], 0);
    chk("R11 portEn dropped", portEn, 0);
    chk("R9 irqErr on fault", irqErr, 1);
    ssN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 fault sticky", modeFault, 1);
    wrCtrl(8'h81);
    chk("R11 fault cleared", modeFault, 0);
    chk("R11 re-enabled", portEn, 1);
  endtask

  initial begin
    slvBytes[0] = 8'h00; slvBytes[1] = 8'h00;
    slvBytes[2] = 8'h00; slvBytes[3] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tBasic();
    tQueue();
    tRates();
    tBackToBack();
    tOverrun();
    tAbort();
    tModeFault();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule